// File: doc/BRIEF.md
# Enabled Modulo-Three Down Counter

This block is a two-bit counter that steps downward through three values. While its count-enable input is high, each rising clock edge moves it from 2 to 1, from 1 to 0, and from 0 back to 2. While the enable is low, the value does not change. The storage is two toggle flip-flops that trigger on the rising edge. A small piece of combinational logic works out the toggle inputs from the present state and the enable.

The code 3 is never part of the cycle, so the toggle equations treat it as a don't-care. With the chosen equations, an enabled edge would move that code to 0, so the counter corrects itself. A synchronous, active-high reset places the counter at 2, the first value of the cycle. The output is the raw two-bit state, with no decoding.

Top module: `mod3_down_ctr`

## Requirements
- R1: While `rst` is 1 at a rising edge, `count` becomes 2 (binary 10) after that edge, whatever the value of `cnt_en`.
- R2: With `rst` at 0, `cnt_en` at 1 and `count` at 2, the next rising edge makes `count` equal to 1.
- R3: With `rst` at 0, `cnt_en` at 1 and `count` at 1, the next rising edge makes `count` equal to 0.
- R4: With `rst` at 0, `cnt_en` at 1 and `count` at 0, the next rising edge makes `count` equal to 2 (wrap).
- R5: With `rst` at 0 and `cnt_en` at 0, a rising edge leaves `count` unchanged.
- R6: After reset, `count` never shows the code 3.
- R7: When `cnt_en` changes from cycle to cycle, `count` advances by exactly one step for each enabled edge and by none for the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the value 2 |
| cnt_en | input | 1 | Count enable; when high, the counter steps down one value per edge |
| count | output | 2 | Present counter state: 2, 1 or 0 |

## Verification
The only state in the block is the output itself. A wrong toggle term therefore shows on `count` at the first rising edge where that term is used, and the error stays visible as a wrong value from then on. A fault in the hold path shows on the first edge with the enable low. A fault in the wrap from 0 shows within three enabled edges of reset. The scoreboard compares the value after every edge, so a divergence is reported in the cycle where it first appears.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int CNT_W = 2;
    localparam int MOD_N = 3;
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_TOP = cnt_t'(MOD_N - 1);

    typedef struct packed {
        cnt_t cnt;
    } ctr_state_t;
endpackage

// File: rtl/mcd_toggle.sv
module mcd_toggle
    import mcd_pkg::*;
(
    input  logic en,
    input  cnt_t q,
    output cnt_t t
);
    // Minimised with code 3 as don't-care; code 3 toggles both bits -> 0
    always_comb begin
        t[1] = en & (q[1] | ~q[0]);
        t[0] = en & (q[1] | q[0]);
    end
endmodule

// File: rtl/mcd_tff_bank.sv
module mcd_tff_bank #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] t,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_tff
        logic bit_d;
        logic bit_q;

        always_comb begin
            bit_d = t[i] ? ~bit_q : bit_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= RST_VAL[i];
            end else begin
                bit_q <= bit_d;
            end
        end

        assign q[i] = bit_q;
    end
endmodule

// File: rtl/mod3_down_ctr.sv
module mod3_down_ctr
    import mcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count
);
    ctr_state_t st_q;
    cnt_t       tgl;
    cnt_t       bank_q;

    mcd_toggle u_toggle (
        .en (cnt_en),
        .q  (st_q.cnt),
        .t  (tgl)
    );

    mcd_tff_bank #(
        .W       (CNT_W),
        .RST_VAL (CNT_TOP)
    ) u_bank (
        .clk (clk),
        .rst (rst),
        .t   (tgl),
        .q   (bank_q)
    );

    always_comb begin
        st_q.cnt = bank_q;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
    input logic       clk,
    input logic       rst,
    input logic       cnt_en,
    input logic [1:0] count
);
    AST_RESET_TO_TWO: assert property (@(posedge clk)
        rst |=> count == 2'd2); // R1

    AST_STEP_2_TO_1: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count == 2'd2) |=> count == 2'd1); // R2

    AST_STEP_1_TO_0: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count == 2'd1) |=> count == 2'd0); // R3

    AST_WRAP_0_TO_2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count == 2'd0) |=> count == 2'd2); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count)); // R5

    AST_NO_CODE_3: assert property (@(posedge clk) disable iff (rst)
        count != 2'd3); // R6
endmodule

bind mod3_down_ctr mcd_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .count  (count)
);

// File: tb/sim_mod3_down_ctr.sv
module sim_mod3_down_ctr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [1:0] count;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] model = 2'd2;

    always #2 clk = ~clk;

    mod3_down_ctr u0 (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .count  (count)
    );

    task automatic drive(input logic r, input logic e, input string force_tag);
        string tg;
        @(negedge clk);
        rst    = r;
        cnt_en = e;
        if (r) begin
            tg = "R1";
            model = 2'd2;
        end else if (!e) begin
            tg = "R5";
        end else begin
            case (model)
                2'd2:    begin tg = "R2"; model = 2'd1; end
                2'd1:    begin tg = "R3"; model = 2'd0; end
                default: begin tg = "R4"; model = 2'd2; end
            endcase
        end
        if (force_tag != "") tg = force_tag;
        exp_q.push_back(model);
        tag_q.push_back(tg);
    endtask

    // monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [1:0] ex;
            string      tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_checks++;
            if (count !== ex) begin
                n_fails++;
                $display("FAIL %s: count=%0d expected=%0d", tg, count, ex);
            end
            if (!rst) begin
                n_checks++;
                if (count === 2'd3) begin
                    n_fails++;
                    $display("FAIL R6: count=%0d expected=not 3", count);
                end
            end
        end
    end

    initial begin
        // R1: reset, with the enable both low and high
        drive(1'b1, 1'b0, "");
        drive(1'b1, 1'b1, "");
        // R2 R3 R4: two full enabled cycles
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, "");
        // R5: hold at 2
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, "");
        // hold at 1 and at 0
        drive(1'b0, 1'b1, "");
        drive(1'b0, 1'b0, "");
        drive(1'b0, 1'b0, "");
        drive(1'b0, 1'b1, "");
        drive(1'b0, 1'b0, "");
        // R7: alternating and irregular enables
        for (int i = 0; i < 12; i++) drive(1'b0, i[0], "R7");
        for (int i = 0; i < 15; i++) drive(1'b0, (i % 3) != 2, "R7");
        // R1: reset mid-cycle overrides enable
        drive(1'b0, 1'b1, "");
        drive(1'b1, 1'b1, "");
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, "");
        @(negedge clk);
        cnt_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule